// File: doc/BRIEF.md
# Configuration Command Controller

This block is a small command engine that lives inside a board-level register window reached over an APB-style bus. Software places an operand in a data register, then writes a command word to a control register. The write both issues and completes the command in a single step. The controller clears two reserved bits of the command word and stores the result. It then compares the word against a short table of recognised commands and sets a status register. If the command is a power-off or restart command, it raises a one-cycle request to the system.

The block answers only when a board identifier input matches a configured value. On any other board the three registers behave as absent: reads return zero and writes are dropped. Transport of configuration traffic to add-on boards is not modelled. Every command that is not in the table completes at once and reports an error.

Top module: `cfgcmd_ctrl`

## Requirements
- R1: After reset the data, control and status registers all read zero, and neither request output is high.
- R2: When `board_id` differs from 12'h190, a read of any offset returns zero and writes are dropped. Once `board_id` is 12'h190 again, the registers still hold their earlier values.
- R3: The data register at offset 0xA0 stores all 32 bits of a write and returns them on a read.
- R4: A write to the control register at offset 0xA4 stores the write data with bits 19 and 18 forced to zero.
- R5: Every control write sets status bit 0 (complete). Status bit 1 (error) is set to 1 when the masked command is in neither entry of the table, and to 0 when it is. Status bits 31:2 read zero.
- R6: A masked command equal to 32'hC0800000 raises `shutdown_req` for exactly one cycle. The pulse starts in the cycle after the accepted write, and the command leaves status at 1. This includes a word that matches only after bits 19:18 are cleared.
- R7: A masked command equal to 32'hC0900000 raises `reboot_req` for exactly one cycle. The pulse starts in the cycle after the accepted write, and the command leaves status at 1. The two requests are never high together.
- R8: A write to the status register at offset 0xA8 stores only write data bits 1:0.
- R9: Reads have no side effect: reading a register again returns the same value, and a read raises no request.
- R10: An offset other than 0xA0, 0xA4 or 0xA8 reads zero, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| board_id | input | 12 | Board type; the registers exist only for the enabled value |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a selected read |
| shutdown_req | output | 1 | One-cycle power-off request |
| reboot_req | output | 1 | One-cycle restart request |

## Verification
The assertions assume that the bus follows a setup phase and then an access phase. Under that rule an accepted write never lands in two cycles in a row. They also assume that `board_id` changes only while the bus is idle. The bench drives every transfer through one task that always inserts a setup cycle and then drops `psel` afterwards. It changes `board_id` only between transfers, so the stimulus stays within these assumptions. The bench then runs the command words, the masked-match corner cases and the disabled-board case against values it computes itself.

// File: rtl/cfgcmd_pkg.sv
package cfgcmd_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_STAT = 2'd3
   } reg_sel_e;

   localparam int STAT_W       = 2;
   localparam int STAT_DONE_IX = 0;
   localparam int STAT_ERR_IX  = 1;

   function automatic logic [STAT_W-1:0] cmd_status(input logic unknown);
      logic [STAT_W-1:0] s;
      s = '0;
      s[STAT_DONE_IX] = 1'b1;
      s[STAT_ERR_IX]  = unknown;
      return s;
   endfunction

endpackage

// File: rtl/cfgcmd_decode.sv
module cfgcmd_decode
   import cfgcmd_pkg::*;
#(
   parameter int              ADDR_W    = 12,
   parameter int              ID_W      = 12,
   parameter logic [ID_W-1:0] ENABLE_ID = 12'h190,
   parameter int              OFS_DATA  = 'hA0,
   parameter int              OFS_CTRL  = 'hA4,
   parameter int              OFS_STAT  = 'hA8
) (
   input  logic [ID_W-1:0]   board_id,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   output logic              bank_on,
   output reg_sel_e          sel,
   output logic              wr_stb,
   output logic              rd_en
);

   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

   if (ADDR_W < 8)
      $error("cfgcmd_decode: ADDR_W too small for register offsets");
   if (OFS_DATA == OFS_CTRL || OFS_DATA == OFS_STAT || OFS_CTRL == OFS_STAT)
      $error("cfgcmd_decode: register offsets must differ");

   assign bank_on = (board_id == ENABLE_ID);

   always_comb begin
      sel = SEL_NONE;
      if (bank_on) begin
         if      (paddr == A_DATA) sel = SEL_DATA;
         else if (paddr == A_CTRL) sel = SEL_CTRL;
         else if (paddr == A_STAT) sel = SEL_STAT;
      end
   end

   assign wr_stb = psel && penable && pwrite && (sel != SEL_NONE);
   assign rd_en  = psel && !pwrite && (sel != SEL_NONE);

endmodule

// File: rtl/cfgcmd_exec.sv
module cfgcmd_exec #(
   parameter int                DATA_W        = 32,
   parameter logic [DATA_W-1:0] CLEAR_MASK    = 32'h000C_0000,
   parameter logic [DATA_W-1:0] SHUTDOWN_CODE = 32'hC080_0000,
   parameter logic [DATA_W-1:0] REBOOT_CODE   = 32'hC090_0000,
   parameter bit                REQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_stb,
   input  logic [DATA_W-1:0] cmd_word,
   output logic [DATA_W-1:0] cmd_masked,
   output logic              cmd_unknown,
   output logic              shutdown_req,
   output logic              reboot_req
);

   localparam int NUM_CMDS = 2;
   localparam logic [NUM_CMDS-1:0][DATA_W-1:0] CODE_TAB = {REBOOT_CODE, SHUTDOWN_CODE};

   if (SHUTDOWN_CODE == REBOOT_CODE)
      $error("cfgcmd_exec: command codes must differ");
   if ((SHUTDOWN_CODE & CLEAR_MASK) != '0 || (REBOOT_CODE & CLEAR_MASK) != '0)
      $error("cfgcmd_exec: command codes overlap the cleared bits");

   logic [NUM_CMDS-1:0] hit;
   logic [NUM_CMDS-1:0] fire;

   assign cmd_masked = cmd_word & ~CLEAR_MASK;

   for (genvar i = 0; i < NUM_CMDS; i++) begin : g_match
      assign hit[i] = (cmd_masked == CODE_TAB[i]);
   end

   assign cmd_unknown = (hit == '0);

   if (REQ_REGISTERED) begin : g_reg
      logic [NUM_CMDS-1:0] req_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_q <= '0;
         else        req_q <= cmd_stb ? hit : '0;
      end
      assign fire = req_q;
   end else begin : g_comb
      assign fire = cmd_stb ? hit : '0;
   end

   assign shutdown_req = fire[0];
   assign reboot_req   = fire[1];

endmodule

// File: rtl/cfgcmd_regs.sv
module cfgcmd_regs
   import cfgcmd_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] cmd_masked,
   input  logic              cmd_unknown,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [STAT_W-1:0] stat_q
);

   if (DATA_W < STAT_W)
      $error("cfgcmd_regs: DATA_W narrower than status field");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         ctrl_q <= '0;
         stat_q <= '0;
      end else if (wr_stb) begin
         unique case (sel)
            SEL_DATA: data_q <= wdata;
            SEL_CTRL: begin
               ctrl_q <= cmd_masked;
               stat_q <= cmd_status(cmd_unknown);
            end
            SEL_STAT: stat_q <= wdata[STAT_W-1:0];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/cfgcmd_ctrl.sv
module cfgcmd_ctrl
   import cfgcmd_pkg::*;
#(
   parameter int                ADDR_W         = 12,
   parameter int                DATA_W         = 32,
   parameter int                ID_W           = 12,
   parameter logic [ID_W-1:0]   ENABLE_ID      = 12'h190,
   parameter logic [DATA_W-1:0] CLEAR_MASK     = 32'h000C_0000,
   parameter logic [DATA_W-1:0] SHUTDOWN_CODE  = 32'hC080_0000,
   parameter logic [DATA_W-1:0] REBOOT_CODE    = 32'hC090_0000,
   parameter bit                REQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ID_W-1:0]   board_id,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              shutdown_req,
   output logic              reboot_req
);

   if (DATA_W != 32)
      $error("cfgcmd_ctrl: command codes assume a 32-bit data path");

   logic              bank_on;
   reg_sel_e          sel;
   logic              wr_stb;
   logic              rd_en;
   logic [DATA_W-1:0] cmd_masked;
   logic              cmd_unknown;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] ctrl_q;
   logic [STAT_W-1:0] stat_q;

   cfgcmd_decode #(
      .ADDR_W(ADDR_W), .ID_W(ID_W), .ENABLE_ID(ENABLE_ID),
      .OFS_DATA('hA0), .OFS_CTRL('hA4), .OFS_STAT('hA8)
   ) u_dec (
      .board_id(board_id), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .bank_on(bank_on), .sel(sel), .wr_stb(wr_stb), .rd_en(rd_en)
   );

   cfgcmd_exec #(
      .DATA_W(DATA_W), .CLEAR_MASK(CLEAR_MASK), .SHUTDOWN_CODE(SHUTDOWN_CODE),
      .REBOOT_CODE(REBOOT_CODE), .REQ_REGISTERED(REQ_REGISTERED)
   ) u_exec (
      .clk(clk), .rst_n(rst_n), .cmd_stb(wr_stb && sel == SEL_CTRL),
      .cmd_word(pwdata), .cmd_masked(cmd_masked), .cmd_unknown(cmd_unknown),
      .shutdown_req(shutdown_req), .reboot_req(reboot_req)
   );

   cfgcmd_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .sel(sel), .wdata(pwdata),
      .cmd_masked(cmd_masked), .cmd_unknown(cmd_unknown),
      .data_q(data_q), .ctrl_q(ctrl_q), .stat_q(stat_q)
   );

   always_comb begin
      prdata = '0;
      if (rd_en) begin
         unique case (sel)
            SEL_DATA: prdata = data_q;
            SEL_CTRL: prdata = ctrl_q;
            SEL_STAT: prdata = {{(DATA_W-STAT_W){1'b0}}, stat_q};
            default:  prdata = '0;
         endcase
      end
   end

   // Bus-side views used by the properties below
   logic bus_wr;
   assign bus_wr = psel && penable && pwrite && (board_id == ENABLE_ID);

   a_r4_ctrl_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && paddr == ADDR_W'('hA4)) |=> ((ctrl_q & CLEAR_MASK) == '0));

   a_r5_done_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && paddr == ADDR_W'('hA4)) |=> stat_q[STAT_DONE_IX]);

   a_r8_stat_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && paddr == ADDR_W'('hA8)) |=> (stat_q == $past(pwdata[STAT_W-1:0])));

   a_r2_off_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (board_id != ENABLE_ID) |-> (prdata == '0));

   a_r7_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(shutdown_req && reboot_req));

   if (REQ_REGISTERED) begin : g_req_chk
      a_r6_shutdown_cause: assert property (@(posedge clk) disable iff (!rst_n)
         shutdown_req |-> $past(bus_wr && paddr == ADDR_W'('hA4)));
      a_r6_shutdown_single: assert property (@(posedge clk) disable iff (!rst_n)
         shutdown_req |=> !shutdown_req);
      a_r7_reboot_cause: assert property (@(posedge clk) disable iff (!rst_n)
         reboot_req |-> $past(bus_wr && paddr == ADDR_W'('hA4)));
   end

endmodule

// File: tb/sim_cfgcmd_ctrl.sv
module sim_cfgcmd_ctrl;

   localparam time HALF = 4ns;
   localparam int  WD_CYCLES = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] board_id = 12'h190;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        shutdown_req, reboot_req;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #HALF clk = ~clk;

   cfgcmd_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .board_id(board_id), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .shutdown_req(shutdown_req), .reboot_req(reboot_req)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Monitor: pops expected read data during each access phase
   always @(posedge clk) begin
      if (psel && penable && !pwrite) begin
         #(HALF/2);
         if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard underflow", prdata, 32'h0);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(prdata === e, t, prdata, e);
         end
      end
   end

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      check(shutdown_req === 1'b0 && reboot_req === 1'b0, "R9 read raised request",
            {30'b0, shutdown_req, reboot_req}, 32'h0);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d,
                     input bit exp_sd, input bit exp_rb, input string tag);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      check(shutdown_req === exp_sd && reboot_req === exp_rb, {tag, " pulse"},
            {30'b0, shutdown_req, reboot_req}, {30'b0, exp_sd, exp_rb});
      @(negedge clk);
      check(shutdown_req === 1'b0 && reboot_req === 1'b0, {tag, " pulse end"},
            {30'b0, shutdown_req, reboot_req}, 32'h0);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check(shutdown_req === 1'b0 && reboot_req === 1'b0, "R1 requests idle",
            {30'b0, shutdown_req, reboot_req}, 32'h0);
      rd(12'hA0, 32'h0, "R1 data reset");
      rd(12'hA4, 32'h0, "R1 ctrl reset");
      rd(12'hA8, 32'h0, "R1 stat reset");

      // R3 data register
      wr(12'hA0, 32'hDEAD_BEEF, 0, 0, "R3 data write");
      rd(12'hA0, 32'hDEAD_BEEF, "R3 data readback");
      wr(12'hA0, 32'h1234_5678, 0, 0, "R3 data write2");
      rd(12'hA0, 32'h1234_5678, "R3 data readback2");

      // R4/R5 unknown command
      wr(12'hA4, 32'hFFFF_FFFF, 0, 0, "R5 unknown cmd");
      rd(12'hA4, 32'hFFF3_FFFF, "R4 ctrl masked");
      rd(12'hA8, 32'h3, "R5 done+error");

      // R8 status write
      wr(12'hA8, 32'hFFFF_FFFE, 0, 0, "R8 stat write");
      rd(12'hA8, 32'h2, "R8 stat low bits");
      wr(12'hA8, 32'h0, 0, 0, "R8 stat clear");
      rd(12'hA8, 32'h0, "R8 stat cleared");

      // R6 shutdown
      wr(12'hA4, 32'hC080_0000, 1, 0, "R6 shutdown");
      rd(12'hA8, 32'h1, "R6 status done");
      wr(12'hA8, 32'h3, 0, 0, "R8 stat set");
      wr(12'hA4, 32'hC08C_0000, 1, 0, "R6 shutdown masked match");
      rd(12'hA4, 32'hC080_0000, "R4 ctrl masked shutdown");
      rd(12'hA8, 32'h1, "R5 recognised clears error");

      // R7 reboot
      wr(12'hA4, 32'hC090_0000, 0, 1, "R7 reboot");
      rd(12'hA8, 32'h1, "R7 status done");
      wr(12'hA4, 32'hC0A0_0000, 0, 0, "R5 near-miss cmd");
      rd(12'hA8, 32'h3, "R5 near-miss error");

      // R9 reads have no side effect
      rd(12'hA8, 32'h3, "R9 repeat read stat");
      rd(12'hA4, 32'hC0A0_0000, "R9 repeat read ctrl");
      rd(12'hA4, 32'hC0A0_0000, "R9 repeat read ctrl2");

      // R10 other offsets
      rd(12'h000, 32'h0, "R10 other offset read");
      rd(12'hAC, 32'h0, "R10 offset 0xAC read");
      wr(12'hAC, 32'hC080_0000, 0, 0, "R10 write other offset");
      wr(12'h9C, 32'hFFFF_FFFF, 0, 0, "R10 write 0x9C");
      rd(12'hA0, 32'h1234_5678, "R10 data untouched");
      rd(12'hA8, 32'h3, "R10 stat untouched");

      // R2 disabled board
      @(negedge clk);
      board_id = 12'h182;
      rd(12'hA0, 32'h0, "R2 off data reads zero");
      rd(12'hA8, 32'h0, "R2 off stat reads zero");
      wr(12'hA0, 32'h0000_0055, 0, 0, "R2 off data write");
      wr(12'hA4, 32'hC080_0000, 0, 0, "R2 off cmd no pulse");
      wr(12'hA8, 32'h0, 0, 0, "R2 off stat write");
      @(negedge clk);
      board_id = 12'h190;
      rd(12'hA0, 32'h1234_5678, "R2 data kept");
      rd(12'hA4, 32'hC0A0_0000, "R2 ctrl kept");
      rd(12'hA8, 32'h3, "R2 stat kept");

      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'h0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule